// File: doc/BRIEF.md
# Synchronous FIFO with Rewind, Mark and Programmable Watermarks

This block is a single-clock FIFO of parameterised width and power-of-two depth. Besides plain write and read, it has two programmable watermark flags. One says the FIFO holds at least a low threshold of words. The other says more free slots remain than a high threshold. Both thresholds come from a serially loaded configuration register, and a read-side command can return them on the data output.

The read side can be rewound. A retransmit command moves the read pointer back to slot zero, or to a location captured earlier with the mark input, and leaves the write side alone. Data already written can therefore be replayed. A partial reset clears both pointers and the output register but keeps the configuration: the output timing mode, the thresholds and the mark. A master reset also latches the timing mode and restores the default thresholds. In the standard timing mode each read returns data one cycle later. In the first-word-fall-through mode the head word is placed on the output without a read.

The read-side control is a two-state machine. ST_RUN is normal operation. ST_REWIND lasts one cycle after a retransmit. Its transitions are: ST_RUN to ST_REWIND when retransmit is sampled high; ST_REWIND to ST_RUN when retransmit is low; ST_REWIND to ST_REWIND when retransmit stays high. Either reset forces ST_RUN.

Top module: `fifo_rt`

## Requirements
- R1: A cycle with mrst high latches fwft_sel as the timing mode (0 standard, 1 fall-through), empties the FIFO, clears dout to zero, clears the mark and sets both thresholds to their defaults (2 and 2). fwft_sel has no effect outside master reset.
- R2: In standard mode, a rd_en cycle with data stored places the oldest word on dout after that clock edge. Words come out in write order.
- R3: full is high exactly when the memory holds DEPTH words. A write while full is ignored and the word is lost.
- R4: In standard mode, a read while empty is ignored, and dout keeps its value.
- R5: almost_empty_n is high exactly when the stored word count is greater than or equal to the low threshold.
- R6: almost_full_n is high exactly when DEPTH minus the stored word count is greater than the high threshold.
- R7: A cycle with ser_en and ser_stb both high shifts ser_din into the threshold register. The low threshold is loaded first, then the high threshold, each least significant bit first and each PW = log2(DEPTH)+1 bits wide. A cycle without both inputs high changes neither threshold.
- R8: A cycle with ofs_rd and rd_en high in ST_RUN puts the thresholds on dout, with the low threshold in bits [PW-1:0], the high threshold in bits [2*PW-1:PW] and zeros above. No FIFO word is consumed. In fall-through mode this happens only while no word is held on dout.
- R9: prst clears both pointers, the word count and dout. It keeps the timing mode, the thresholds and the mark.
- R10: retx moves the read pointer to the mark if one is set, and otherwise to zero. It leaves the write pointer unchanged and sets the word count to the write pointer minus the new read pointer. empty is high in the following cycle (ST_REWIND).
- R11: A cycle with mark high and retx low captures the current read pointer as the mark. The mark stays set until master reset.
- R12: In fall-through mode, the head word appears on dout without a read, and empty goes low while it is held. rd_en advances to the next word, or sets empty when none remains. A retransmit drops the held word. The word held on dout does not count toward the stored word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| fwft_sel | input | 1 | Timing mode sampled during master reset |
| wr_en | input | 1 | Write request |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| dout | output | WIDTH | Read data or threshold readback |
| empty | output | 1 | No data available (fall-through: no word held) |
| full | output | 1 | Memory holds DEPTH words |
| almost_empty_n | output | 1 | High when count >= low threshold |
| almost_full_n | output | 1 | High when free slots > high threshold |
| retx | input | 1 | Retransmit: rewind read pointer |
| mark | input | 1 | Capture read pointer as rewind target |
| ofs_rd | input | 1 | With rd_en, return thresholds on dout |
| ser_en | input | 1 | Serial threshold load enable |
| ser_stb | input | 1 | Serial shift strobe |
| ser_din | input | 1 | Serial threshold data |

## Verification
The assertions assume that a rewind target is never overtaken: between a marked or zero location and a retransmit, no more than DEPTH words are written past it, so the count difference stays meaningful. They also assume that the reset inputs are held high from time zero. The stimulus starts under master reset. It never writes more than DEPTH words beyond the mark before rewinding, and it drives every input one time unit after the clock edge, so each cycle sees settled values.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REWIND = 1'b1
    } rd_state_e;
endpackage

// File: rtl/fifo_rt_cfg.sv
module fifo_rt_cfg #(
    parameter int PW     = 4,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 2
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          fwft_in,
    input  logic          ser_en,
    input  logic          ser_stb,
    input  logic          ser_din,
    output logic          fwft,
    output logic [PW-1:0] ae_ofs,
    output logic [PW-1:0] af_ofs
);
    localparam int SW = 2 * PW;

    logic [SW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (mrst) begin
            fwft <= fwft_in;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            sreg <= {PW'(AF_DEF), PW'(AE_DEF)};
        end else if (ser_en && ser_stb) begin
            sreg <= {ser_din, sreg[SW-1:1]};
        end
    end

    assign ae_ofs = sreg[PW-1:0];
    assign af_ofs = sreg[SW-1:PW];

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable(fwft));

    // R7
    ser_idle_chk: assert property (@(posedge clk) disable iff (mrst)
        !(ser_en && ser_stb) |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
    parameter int WIDTH = 16,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             fwft,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             ofs_rd,
    input  logic             retx,
    input  logic             mark,
    input  logic [WIDTH-1:0] ofs_word,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [AW-1:0]    mem_raddr,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      count,
    output logic             empty
);
    localparam int            PW      = AW + 1;
    localparam int            DEPTH   = 1 << AW;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    rd_state_e     state, state_nx;
    logic [PW-1:0] wptr, rptr, mark_ptr, tgt;
    logic          mark_vld, ovalid;
    logic          wr_ok, rd_std, pop_ff, pop_any, rb, drain, running;

    // State register
    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    state_nx = retx ? ST_REWIND : ST_RUN;
            ST_REWIND: state_nx = retx ? ST_REWIND : ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        running = (state == ST_RUN) && !retx;
        empty   = fwft ? !ovalid : ((state == ST_REWIND) || (count == '0));
    end

    assign wr_ok   = wr_en && (count != DEPTH_V);
    assign rd_std  = !fwft && running && rd_en && !ofs_rd && (count != '0);
    assign pop_ff  = fwft && running && (count != '0) && (!ovalid || (rd_en && !ofs_rd));
    assign pop_any = rd_std || pop_ff;
    assign drain   = fwft && running && ovalid && rd_en && !ofs_rd && (count == '0);
    assign rb      = running && ofs_rd && rd_en && (!fwft || !ovalid);
    assign tgt     = mark_vld ? mark_ptr : '0;

    assign mem_we    = wr_ok && !mrst && !prst;
    assign mem_waddr = wptr[AW-1:0];
    assign mem_raddr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
            dout   <= '0;
            ovalid <= 1'b0;
            if (mrst) begin
                mark_vld <= 1'b0;
                mark_ptr <= '0;
            end
        end else begin
            if (wr_ok) begin
                wptr <= wptr + 1'b1;
            end
            if (retx) begin
                rptr   <= tgt;
                count  <= wptr - tgt + PW'(wr_ok);
                ovalid <= 1'b0;
            end else begin
                if (pop_any) begin
                    rptr <= rptr + 1'b1;
                end
                count <= count + PW'(wr_ok) - PW'(pop_any);
                if (mark) begin
                    mark_ptr <= rptr;
                    mark_vld <= 1'b1;
                end
                if (pop_ff) begin
                    ovalid <= 1'b1;
                end else if (drain) begin
                    ovalid <= 1'b0;
                end
            end
            if (pop_any) begin
                dout <= mem_rdata;
            end else if (rb) begin
                dout <= ofs_word;
            end
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        count <= DEPTH_V);

    // R3
    full_write_block_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (count == DEPTH_V) |=> (wptr == $past(wptr)));

    // R4
    empty_read_block_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (!fwft && count == '0 && !retx) |=> (rptr == $past(rptr)));

    // R10
    rewind_wptr_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (retx && !wr_en) |=> (wptr == $past(wptr)));

    // R10
    rewind_empty_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        retx |=> empty);

    // R9
    partial_clear_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> (dout == '0 && count == '0));
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
    parameter int WIDTH  = 16,
    parameter int AW     = 3,
    parameter int AE_DEF = 2,
    parameter int AF_DEF = 2
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             fwft_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             almost_empty_n,
    output logic             almost_full_n,
    input  logic             retx,
    input  logic             mark,
    input  logic             ofs_rd,
    input  logic             ser_en,
    input  logic             ser_stb,
    input  logic             ser_din
);
    localparam int            PW      = AW + 1;
    localparam int            DEPTH   = 1 << AW;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    logic             fwft, mem_we;
    logic [PW-1:0]    ae_ofs, af_ofs, count, free_slots;
    logic [AW-1:0]    mem_waddr, mem_raddr;
    logic [WIDTH-1:0] mem_rdata, ofs_word;

    fifo_rt_cfg #(.PW(PW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_cfg (
        .clk(clk), .mrst(mrst), .fwft_in(fwft_sel),
        .ser_en(ser_en), .ser_stb(ser_stb), .ser_din(ser_din),
        .fwft(fwft), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    fifo_rt_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign ofs_word = WIDTH'({af_ofs, ae_ofs});

    fifo_rt_ctrl #(.WIDTH(WIDTH), .AW(AW)) u_ctrl (
        .clk(clk), .mrst(mrst), .prst(prst), .fwft(fwft),
        .wr_en(wr_en), .rd_en(rd_en), .ofs_rd(ofs_rd), .retx(retx), .mark(mark),
        .ofs_word(ofs_word), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
        .dout(dout), .count(count), .empty(empty)
    );

    assign free_slots     = DEPTH_V - count;
    assign full           = (count == DEPTH_V);
    assign almost_empty_n = (count >= ae_ofs);
    assign almost_full_n  = (free_slots > af_ofs);

    // R6
    full_flag_order_chk: assert property (@(posedge clk) disable iff (mrst)
        full |-> !almost_full_n);
endmodule

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;
    localparam int WIDTH = 16;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0, mark = 1'b0;
    logic             ofs_rd = 1'b0, ser_en = 1'b0, ser_stb = 1'b0, ser_din = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             empty, full, almost_empty_n, almost_full_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fifo_rt u_fifo_rt (
        .clk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
        .empty(empty), .full(full), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .retx(retx), .mark(mark),
        .ofs_rd(ofs_rd), .ser_en(ser_en), .ser_stb(ser_stb), .ser_din(ser_din)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(string tag, int cnt, int n, int m);
        chk({tag, " R3 full"}, 32'(full), 32'(cnt == DEPTH));
        chk({tag, " R5 almost_empty_n"}, 32'(almost_empty_n), 32'(cnt >= n));
        chk({tag, " R6 almost_full_n"}, 32'(almost_full_n), 32'((DEPTH - cnt) > m));
    endtask

    task automatic ser_load(logic [3:0] n, logic [3:0] m);
        for (int i = 0; i < 8; i++) begin
            ser_en  = 1'b1;
            ser_stb = 1'b1;
            ser_din = (i < 4) ? n[i] : m[i-4];
            tick();
        end
        ser_en  = 1'b0;
        ser_stb = 1'b0;
        ser_din = 1'b0;
    endtask

    task automatic readback(string tag, logic [15:0] exp);
        ofs_rd = 1'b1;
        rd_en  = 1'b1;
        tick();
        ofs_rd = 1'b0;
        rd_en  = 1'b0;
        chk({tag, " R8 readback"}, 32'(dout), 32'(exp));
    endtask

    task automatic read_one();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Master reset, standard mode
        tick();
        tick();
        mrst = 1'b0;
        fwft_sel = 1'b1;   // must be ignored outside master reset (R1)
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 dout after reset", 32'(dout), 32'd0);
        chk_flags("R1 reset", 0, 2, 2);
        readback("R1 default thresholds", 16'h0022);

        // Serial load low=3, high=2
        ser_load(4'd3, 4'd2);
        // Cycles without both strobes must not shift (R7)
        ser_en = 1'b1; ser_din = 1'b1; tick();
        ser_en = 1'b0; ser_stb = 1'b1; tick();
        ser_stb = 1'b0; ser_din = 1'b0;
        readback("R7 loaded thresholds", 16'h0023);
        chk("R8 readback leaves fifo empty", 32'(empty), 32'd1);

        // Fill past full; standard mode kept despite fwft_sel (R1)
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_en = 1'b1;
            din   = 16'hA000 + 16'(i);
            tick();
            wr_en = 1'b0;
            chk_flags($sformatf("R3 fill %0d", i), (i + 1 > DEPTH) ? DEPTH : i + 1, 3, 2);
            chk("R1 standard mode keeps dout", 32'(dout), 32'h0023);
        end

        // First read then mark at read pointer 1
        read_one();
        chk("R2 first word", 32'(dout), 32'hA000);
        mark = 1'b1; tick(); mark = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            read_one();
            chk($sformatf("R2 word %0d", k), 32'(dout), 32'hA000 + 32'(k));
            chk_flags($sformatf("R2 drain %0d", k), DEPTH - 1 - k, 3, 2);
        end
        chk("R3 overflow words lost, empty", 32'(empty), 32'd1);
        read_one();
        chk("R4 read while empty holds dout", 32'(dout), 32'hA007);

        // Retransmit to mark (slot 1)
        retx = 1'b1; tick(); retx = 1'b0;
        chk("R10 empty in rewind cycle", 32'(empty), 32'd1);
        tick();
        chk("R10 data available after rewind", 32'(empty), 32'd0);
        chk_flags("R10 count after rewind", 7, 3, 2);
        for (int k = 1; k < DEPTH; k++) begin
            read_one();
            chk($sformatf("R11 replay word %0d", k), 32'(dout), 32'hA000 + 32'(k));
        end
        chk("R10 empty after replay", 32'(empty), 32'd1);

        // Partial reset
        prst = 1'b1; tick(); prst = 1'b0;
        chk("R9 dout cleared", 32'(dout), 32'd0);
        chk("R9 empty", 32'(empty), 32'd1);
        chk_flags("R9 flags", 0, 3, 2);
        readback("R9 thresholds kept", 16'h0023);
        wr_en = 1'b1; din = 16'h5A5A; tick(); wr_en = 1'b0;
        tick();
        chk("R9 standard mode kept", 32'(dout), 32'h0023);
        read_one();
        chk("R9 pointers restart", 32'(dout), 32'h5A5A);
        // Mark kept across partial reset: mark slot 1 holds the write at index 1
        wr_en = 1'b1; din = 16'h6B6B; tick(); wr_en = 1'b0;
        retx = 1'b1; tick(); retx = 1'b0;
        tick();
        read_one();
        chk("R11 mark survives partial reset", 32'(dout), 32'h6B6B);

        // Master reset into fall-through mode
        mrst = 1'b1; fwft_sel = 1'b1; tick(); mrst = 1'b0; fwft_sel = 1'b0;
        readback("R1 defaults restored", 16'h0022);
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; din = 16'hC000 + 16'(i); tick();
        end
        wr_en = 1'b0;
        chk("R12 head word presented", 32'(dout), 32'hC000);
        chk("R12 not empty", 32'(empty), 32'd0);
        chk_flags("R12 held word excluded", 2, 2, 2);
        read_one();
        chk("R12 advance 1", 32'(dout), 32'hC001);
        read_one();
        chk("R12 advance 2", 32'(dout), 32'hC002);
        read_one();
        chk("R12 empty after last", 32'(empty), 32'd1);
        retx = 1'b1; tick(); retx = 1'b0;
        chk("R10 fall-through rewind empty", 32'(empty), 32'd1);
        tick();
        chk("R10 rewind cycle over, not yet refilled", 32'(empty), 32'd1);
        tick();
        chk("R11 mark cleared by master reset, rewind to zero", 32'(dout), 32'hC000);
        chk("R12 refilled", 32'(empty), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule